// File: doc/BRIEF.md
# Interrupt Request Flag Unit

This block keeps the interrupt request flags for a small microcontroller with ten interrupt sources. The sources are two active-low external pins, three timers, two serial ports, an I2C port, a display data channel port and a USB port. Each flag is set by an event from its peripheral. Each source has its own clearing rule. Some flags are cleared by hardware when the CPU acknowledges the vector. Some are cleared only by a software write-one-to-clear. The external pins in level mode make their flag track the pin. The block never resolves priority and never forms a vector address.

Each external pin goes through a synchronizer. A per-pin type bit then selects level or falling-edge capture. A takeover option lets an ADC conversion-done strobe drive the external interrupt 1 request in place of the pin. Timer 2, DDC and USB each merge several flags into one source request. Software programs the control bits, the enables and the clear masks through a byte-wide write port. The CPU side sees two registered 10-bit vectors: the raw pending sources, and the pending sources gated by the per-source and global enables.

Top module: `irq_flag_unit`

## Requirements
- R1: After reset, `pend_o` and `req_o` are all zero, every enable is zero, and both external pins are in level mode.
- R2: Source bit order is 0 ext0, 1 timer0, 2 ext1, 3 timer1, 4 serial0, 5 timer2, 6 I2C, 7 serial1, 8 DDC, 9 USB. `req_o` is the registered value of pending AND enable, forced to zero while the global enable is 0. `pend_o` shows pending sources whatever the enables are. Register map: address 0 is control (bit0 ext0 edge mode, bit1 ext1 edge mode, bit2 ADC takeover, bit3 timer 2 external trigger enable, bit7 global enable). Address 1 holds the enables for sources 7..0. Address 2 bits 1:0 hold the enables for sources 9..8.
- R3: In edge mode, a high-then-low pair of synchronized pin samples sets the external flag. The flag then holds after the pin returns high. An acknowledge of that source clears it, and a pin held low does not set it again.
- R4: In level mode, the external flag equals the inverted synchronized pin. An acknowledge has no effect on it.
- R5: Timer 0 and timer 1 overflow strobes set their flags. An acknowledge of source 1 or 3 clears them.
- R6: The timer 2 request is the OR of an overflow flag and an external-trigger flag. The trigger flag is set by a falling edge on the trigger pin only while control bit3 is 1. An acknowledge clears neither flag. Writing 1 to bit0 (overflow) or bit1 (trigger) at address 3 clears them.
- R7: The I2C strobe sets its flag, and an acknowledge of source 6 clears it.
- R8: With ADC takeover on, the ext1 pin is ignored. The ADC done strobe sets the ext1 flag, and an acknowledge of source 2 clears it.
- R9: The DDC request is the OR of three flags. The serial flag is cleared by an acknowledge of source 8. The mode-1 event flag is cleared by writing bit2 at address 3. The switch flag is set when the mode input goes from 0 to 1, is cleared by writing bit3 at address 3, and is not set by a 1-to-0 change.
- R10: The USB request is the OR of seven flags set by `usb_evt` bits 0..6 (ep0 tx, ep0 rx, ep1 tx, ep2 tx, suspend, resume, end-of-packet). Writing 1 to bit n at address 4 clears flag n only. An acknowledge clears none of them.
- R11: Serial 0 and serial 1 flags are cleared only by writing bit4 and bit5 at address 3. An acknowledge has no effect on them.
- R12: When a set event and a software clear of the same flag fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext0_n | input | 1 | External interrupt 0 pin, active low, asynchronous |
| ext1_n | input | 1 | External interrupt 1 pin, active low, asynchronous |
| t2ex_n | input | 1 | Timer 2 external trigger pin, asynchronous |
| tmr0_ovf | input | 1 | Timer 0 overflow strobe |
| tmr1_ovf | input | 1 | Timer 1 overflow strobe |
| tmr2_ovf | input | 1 | Timer 2 overflow strobe |
| ser0_evt | input | 1 | Serial port 0 event strobe |
| ser1_evt | input | 1 | Serial port 1 event strobe |
| i2c_evt | input | 1 | I2C event strobe |
| ddc2_evt | input | 1 | DDC serial-mode event strobe |
| ddc1_evt | input | 1 | DDC mode-1 event strobe |
| ddc_mode | input | 1 | DDC protocol mode level (0 mode 1, 1 mode 2) |
| usb_evt | input | 7 | USB event strobes |
| adc_done | input | 1 | ADC conversion-done strobe |
| ack_valid | input | 1 | Vector acknowledge strobe |
| ack_src | input | 4 | Index of the acknowledged source |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| req_o | output | 10 | Enabled pending requests, registered |
| pend_o | output | 10 | Raw pending sources, registered |

## Verification
Two cases are the hardest to reach from the ports. The first is a set strobe and a write-one-to-clear of the same flag landing on one clock edge. The bench gets there by raising the timer 2 overflow strobe and the clear write on the same falling edge, so that both reach the same rising edge. The second is the per-bit clearing of the seven USB flags, which the outputs show only through their OR. The bench raises one USB flag at a time and sweeps all 128 clear masks against it. The enable gating gets a full sweep of all 1024 enable patterns while every source is held pending.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC  = 10;
  localparam int SRC_W = $clog2(NSRC);
  localparam int USB_N = 7;

  localparam int S_EXT0 = 0;
  localparam int S_TMR0 = 1;
  localparam int S_EXT1 = 2;
  localparam int S_TMR1 = 3;
  localparam int S_SER0 = 4;
  localparam int S_TMR2 = 5;
  localparam int S_I2C  = 6;
  localparam int S_SER1 = 7;
  localparam int S_DDC  = 8;
  localparam int S_USB  = 9;

  localparam int F_IE0   = 0;
  localparam int F_TF0   = 1;
  localparam int F_IE1   = 2;
  localparam int F_TF1   = 3;
  localparam int F_SER0  = 4;
  localparam int F_TF2   = 5;
  localparam int F_EXF2  = 6;
  localparam int F_I2C   = 7;
  localparam int F_SER1  = 8;
  localparam int F_DDC2  = 9;
  localparam int F_DDC1  = 10;
  localparam int F_DDCSW = 11;
  localparam int F_USB0  = 12;
  localparam int NFLAG   = F_USB0 + USB_N;

  localparam int C_TF2   = 0;
  localparam int C_EXF2  = 1;
  localparam int C_DDC1  = 2;
  localparam int C_DDCSW = 3;
  localparam int C_SER0  = 4;
  localparam int C_SER1  = 5;
  localparam int NCLR    = 6;

  localparam int A_CTRL    = 0;
  localparam int A_EN_LO   = 1;
  localparam int A_EN_HI   = 2;
  localparam int A_CLR     = 3;
  localparam int A_USB_CLR = 4;

  typedef struct packed {
    logic gie;
    logic exen2;
    logic adc_sel;
    logic it1;
    logic it0;
  } ctrl_t;
endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  output logic lvl,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '1;
      prev  <= 1'b1;
    end else begin
      chain <= {chain[STAGES-2:0], pin_n};
      prev  <= chain[STAGES-1];
    end
  end

  assign lvl  = chain[STAGES-1];
  assign fall = prev & ~chain[STAGES-1];

  p_fall_once_r3: assert property (@(posedge clk) disable iff (rst)
    fall |=> !fall);
endmodule

// File: rtl/irq_flag_cell.sv
module irq_flag_cell (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  input  logic fol_en,
  input  logic fol_val,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)          q <= 1'b0;
    else if (fol_en)  q <= fol_val;
    else if (set_i)   q <= 1'b1;
    else if (clr_i)   q <= 1'b0;
  end

  p_set_wins_r12: assert property (@(posedge clk) disable iff (rst)
    (set_i && !fol_en) |=> q);

  p_clr_takes_r7: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i && !fol_en) |=> !q);

  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (!set_i && !clr_i && !fol_en) |=> $stable(q));
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_pkg::*;
#(
  parameter int AW = 3,
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  output ctrl_t            ctrl,
  output logic [NSRC-1:0]  en,
  output logic [NCLR-1:0]  swclr,
  output logic [USB_N-1:0] swclr_usb
);
  localparam int HI_W = NSRC - DW;

  logic [DW-1:0]   en_lo;
  logic [HI_W-1:0] en_hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl  <= '0;
      en_lo <= '0;
      en_hi <= '0;
    end else if (wr_en) begin
      if (wr_addr == AW'(A_CTRL)) begin
        ctrl.it0     <= wr_data[0];
        ctrl.it1     <= wr_data[1];
        ctrl.adc_sel <= wr_data[2];
        ctrl.exen2   <= wr_data[3];
        ctrl.gie     <= wr_data[7];
      end
      if (wr_addr == AW'(A_EN_LO)) en_lo <= wr_data;
      if (wr_addr == AW'(A_EN_HI)) en_hi <= wr_data[HI_W-1:0];
    end
  end

  assign en        = {en_hi, en_lo};
  assign swclr     = (wr_en && wr_addr == AW'(A_CLR))     ? wr_data[NCLR-1:0]  : '0;
  assign swclr_usb = (wr_en && wr_addr == AW'(A_USB_CLR)) ? wr_data[USB_N-1:0] : '0;

  p_en_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(en));
endmodule

// File: rtl/irq_out_stage.sv
module irq_out_stage #(
  parameter int N = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pend_i,
  input  logic [N-1:0] en_i,
  input  logic         gie_i,
  output logic [N-1:0] req_o,
  output logic [N-1:0] pend_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      req_o  <= '0;
      pend_o <= '0;
    end else begin
      pend_o <= pend_i;
      req_o  <= gie_i ? (pend_i & en_i) : '0;
    end
  end

  p_gie_off_r2: assert property (@(posedge clk) disable iff (rst)
    !gie_i |=> (req_o == '0));

  p_req_in_pend_r2: assert property (@(posedge clk) disable iff (rst)
    ((req_o & ~pend_o) == '0));
endmodule

// File: rtl/irq_flag_unit.sv
module irq_flag_unit
  import irq_pkg::*;
#(
  parameter int AW          = 3,
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ext0_n,
  input  logic             ext1_n,
  input  logic             t2ex_n,
  input  logic             tmr0_ovf,
  input  logic             tmr1_ovf,
  input  logic             tmr2_ovf,
  input  logic             ser0_evt,
  input  logic             ser1_evt,
  input  logic             i2c_evt,
  input  logic             ddc2_evt,
  input  logic             ddc1_evt,
  input  logic             ddc_mode,
  input  logic [USB_N-1:0] usb_evt,
  input  logic             adc_done,
  input  logic             ack_valid,
  input  logic [SRC_W-1:0] ack_src,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  output logic [NSRC-1:0]  req_o,
  output logic [NSRC-1:0]  pend_o
);
  localparam int NPIN = 3;

  ctrl_t             ctrl;
  logic [NSRC-1:0]   en;
  logic [NCLR-1:0]   swclr;
  logic [USB_N-1:0]  swclr_usb;
  logic [NPIN-1:0]   pins_n, lvl, fall;
  logic [NSRC-1:0]   ack_hit;
  logic [NFLAG-1:0]  set_v, clr_v, fen_v, fval_v, flag;
  logic [NSRC-1:0]   src_pend;
  logic              ddc_mode_q;

  irq_cfg_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ctrl(ctrl), .en(en), .swclr(swclr), .swclr_usb(swclr_usb)
  );

  assign pins_n = {t2ex_n, ext1_n, ext0_n};

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    irq_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst(rst), .pin_n(pins_n[p]), .lvl(lvl[p]), .fall(fall[p])
    );
  end

  always_comb begin
    for (int i = 0; i < NSRC; i++)
      ack_hit[i] = ack_valid && (ack_src == SRC_W'(i));
  end

  always_ff @(posedge clk) begin
    if (rst) ddc_mode_q <= 1'b0;
    else     ddc_mode_q <= ddc_mode;
  end

  always_comb begin
    set_v  = '0;
    clr_v  = '0;
    fen_v  = '0;
    fval_v = '0;
    // external 0: edge capture or level follow
    set_v[F_IE0]  = fall[0];
    clr_v[F_IE0]  = ack_hit[S_EXT0];
    fen_v[F_IE0]  = !ctrl.it0;
    fval_v[F_IE0] = !lvl[0];
    // external 1: pin or ADC takeover
    set_v[F_IE1]  = ctrl.adc_sel ? adc_done : fall[1];
    clr_v[F_IE1]  = ack_hit[S_EXT1];
    fen_v[F_IE1]  = !ctrl.it1 && !ctrl.adc_sel;
    fval_v[F_IE1] = !lvl[1];
    // timers 0/1: hardware clear on acknowledge
    set_v[F_TF0]  = tmr0_ovf;
    clr_v[F_TF0]  = ack_hit[S_TMR0];
    set_v[F_TF1]  = tmr1_ovf;
    clr_v[F_TF1]  = ack_hit[S_TMR1];
    // timer 2: software clear only
    set_v[F_TF2]  = tmr2_ovf;
    clr_v[F_TF2]  = swclr[C_TF2];
    set_v[F_EXF2] = fall[2] && ctrl.exen2;
    clr_v[F_EXF2] = swclr[C_EXF2];
    // serial ports: software clear only
    set_v[F_SER0] = ser0_evt;
    clr_v[F_SER0] = swclr[C_SER0];
    set_v[F_SER1] = ser1_evt;
    clr_v[F_SER1] = swclr[C_SER1];
    // I2C: hardware clear
    set_v[F_I2C]  = i2c_evt;
    clr_v[F_I2C]  = ack_hit[S_I2C];
    // DDC group
    set_v[F_DDC2]  = ddc2_evt;
    clr_v[F_DDC2]  = ack_hit[S_DDC];
    set_v[F_DDC1]  = ddc1_evt;
    clr_v[F_DDC1]  = swclr[C_DDC1];
    set_v[F_DDCSW] = ddc_mode && !ddc_mode_q;
    clr_v[F_DDCSW] = swclr[C_DDCSW];
    // USB group: per-bit software clear
    for (int u = 0; u < USB_N; u++) begin
      set_v[F_USB0+u] = usb_evt[u];
      clr_v[F_USB0+u] = swclr_usb[u];
    end
  end

  for (genvar f = 0; f < NFLAG; f++) begin : g_flag
    irq_flag_cell u_cell (
      .clk(clk), .rst(rst), .set_i(set_v[f]), .clr_i(clr_v[f]),
      .fol_en(fen_v[f]), .fol_val(fval_v[f]), .q(flag[f])
    );
  end

  always_comb begin
    src_pend         = '0;
    src_pend[S_EXT0] = flag[F_IE0];
    src_pend[S_TMR0] = flag[F_TF0];
    src_pend[S_EXT1] = flag[F_IE1];
    src_pend[S_TMR1] = flag[F_TF1];
    src_pend[S_SER0] = flag[F_SER0];
    src_pend[S_TMR2] = flag[F_TF2] | flag[F_EXF2];
    src_pend[S_I2C]  = flag[F_I2C];
    src_pend[S_SER1] = flag[F_SER1];
    src_pend[S_DDC]  = flag[F_DDC2] | flag[F_DDC1] | flag[F_DDCSW];
    src_pend[S_USB]  = |flag[NFLAG-1:F_USB0];
  end

  irq_out_stage #(.N(NSRC)) u_out (
    .clk(clk), .rst(rst), .pend_i(src_pend), .en_i(en), .gie_i(ctrl.gie),
    .req_o(req_o), .pend_o(pend_o)
  );

  p_lvl_follow_r4: assert property (@(posedge clk) disable iff (rst)
    !ctrl.it0 |=> (flag[F_IE0] == !$past(lvl[0])));

  p_tmr_ack_r5: assert property (@(posedge clk) disable iff (rst)
    (ack_hit[S_TMR0] && !tmr0_ovf) |=> !flag[F_TF0]);

  p_t2_keep_r6: assert property (@(posedge clk) disable iff (rst)
    (flag[F_TF2] && !swclr[C_TF2]) |=> flag[F_TF2]);

  p_exf2_gate_r6: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.exen2 && !flag[F_EXF2]) |=> !flag[F_EXF2]);

  p_adc_pin_r8: assert property (@(posedge clk) disable iff (rst)
    (ctrl.adc_sel && !adc_done && !flag[F_IE1]) |=> !flag[F_IE1]);

  p_ddc_switch_r9: assert property (@(posedge clk) disable iff (rst)
    (!ddc_mode && !flag[F_DDCSW]) |=> !flag[F_DDCSW]);

  p_usb_keep_r10: assert property (@(posedge clk) disable iff (rst)
    (flag[F_USB0] && !swclr_usb[0]) |=> flag[F_USB0]);

  p_reset_r1: assert property (@(posedge clk)
    $past(rst) |-> (req_o == '0 && pend_o == '0));
endmodule

// File: tb/test_irq_flag_unit.sv
`timescale 1ns/1ps
module test_irq_flag_unit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ext0_n = 1'b1, ext1_n = 1'b1, t2ex_n = 1'b1;
  logic tmr0_ovf = 0, tmr1_ovf = 0, tmr2_ovf = 0, ser0_evt = 0, ser1_evt = 0;
  logic i2c_evt = 0, ddc2_evt = 0, ddc1_evt = 0, ddc_mode = 0, adc_done = 0;
  logic [6:0] usb_evt = '0;
  logic ack_valid = 0;
  logic [3:0] ack_src = '0;
  logic wr_en = 0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [9:0] req_o, pend_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_flag_unit i_irq_flag_unit (
    .clk(clk), .rst(rst), .ext0_n(ext0_n), .ext1_n(ext1_n), .t2ex_n(t2ex_n),
    .tmr0_ovf(tmr0_ovf), .tmr1_ovf(tmr1_ovf), .tmr2_ovf(tmr2_ovf),
    .ser0_evt(ser0_evt), .ser1_evt(ser1_evt), .i2c_evt(i2c_evt),
    .ddc2_evt(ddc2_evt), .ddc1_evt(ddc1_evt), .ddc_mode(ddc_mode),
    .usb_evt(usb_evt), .adc_done(adc_done), .ack_valid(ack_valid),
    .ack_src(ack_src), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .req_o(req_o), .pend_o(pend_o)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    wr_en = 1; wr_addr = a[2:0]; wr_data = d[7:0];
    tick(1);
    wr_en = 0;
  endtask

  task automatic ack(input int s);
    ack_valid = 1; ack_src = s[3:0];
    tick(1);
    ack_valid = 0;
  endtask

  // strobe k: 0 tmr0 1 tmr1 2 tmr2 3 ser0 4 ser1 5 i2c 6 ddc2 7 ddc1 8 adc, 10+n usb bit n
  task automatic ev(input int k);
    case (k)
      0: tmr0_ovf = 1;  1: tmr1_ovf = 1;  2: tmr2_ovf = 1;
      3: ser0_evt = 1;  4: ser1_evt = 1;  5: i2c_evt = 1;
      6: ddc2_evt = 1;  7: ddc1_evt = 1;  8: adc_done = 1;
      default: usb_evt[k-10] = 1;
    endcase
    tick(1);
    {tmr0_ovf, tmr1_ovf, tmr2_ovf, ser0_evt, ser1_evt, i2c_evt, ddc2_evt, ddc1_evt, adc_done} = '0;
    usb_evt = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst = 0;
    tick(1);
    chk("R1 pend after reset", pend_o, 0);
    chk("R1 req after reset", req_o, 0);
    wr(0, 8'h80);
    ev(0); tick(1);
    chk("R1 enables zero after reset", req_o, 0);
    chk("R2 pend visible while disabled", pend_o, 10'h002);
    wr(1, 8'hFF); wr(2, 8'h03); tick(1);
    chk("R2 req follows enable", req_o, 10'h002);

    // timers 0/1
    ack(1); tick(1);
    chk("R5 timer0 cleared by ack", pend_o, 0);
    ev(1); tick(1);
    chk("R5 timer1 set", pend_o, 10'h008);
    ack(3); tick(1);
    chk("R5 timer1 cleared by ack", pend_o, 0);

    // level mode ext0 (reset default)
    ext0_n = 0; tick(5);
    chk("R4 level mode follows low pin", pend_o, 10'h001);
    ack(0); tick(1);
    chk("R4 ack ignored in level mode", pend_o, 10'h001);
    ext0_n = 1; tick(5);
    chk("R4 level mode follows high pin", pend_o, 0);

    // edge mode ext0
    wr(0, 8'h81); tick(2);
    chk("R3 edge mode idle", pend_o, 0);
    ext0_n = 0; tick(5);
    chk("R3 falling edge sets flag", pend_o, 10'h001);
    ack(0); tick(4);
    chk("R3 ack clears, held-low pin no re-set", pend_o, 0);
    ext0_n = 1; tick(5);
    chk("R3 rising pin no set", pend_o, 0);
    ext0_n = 0; tick(5); ext0_n = 1; tick(5);
    chk("R3 flag holds after pin returns high", pend_o, 10'h001);
    ack(0); tick(1);
    chk("R3 ack clears held flag", pend_o, 0);
    wr(0, 8'h80);

    // I2C
    ev(5); tick(1);
    chk("R7 i2c set", pend_o, 10'h040);
    ack(6); tick(1);
    chk("R7 i2c cleared by ack", pend_o, 0);

    // serial ports
    ev(3); ev(4); tick(1);
    chk("R11 serial flags set", pend_o, 10'h090);
    ack(4); ack(7); tick(1);
    chk("R11 ack ignored for serial", pend_o, 10'h090);
    wr(3, 8'h10); tick(1);
    chk("R11 serial0 software clear", pend_o, 10'h080);
    wr(3, 8'h20); tick(1);
    chk("R11 serial1 software clear", pend_o, 0);

    // timer 2
    ev(2); tick(1);
    chk("R6 timer2 overflow set", pend_o, 10'h020);
    ack(5); tick(1);
    chk("R6 ack does not clear timer2", pend_o, 10'h020);
    wr(3, 8'h01); tick(1);
    chk("R6 timer2 software clear", pend_o, 0);
    t2ex_n = 0; tick(5); t2ex_n = 1; tick(5);
    chk("R6 trigger ignored while disabled", pend_o, 0);
    wr(0, 8'h88);
    t2ex_n = 0; tick(5); t2ex_n = 1; tick(2);
    chk("R6 trigger edge sets flag", pend_o, 10'h020);
    ack(5); tick(1);
    chk("R6 ack does not clear trigger flag", pend_o, 10'h020);
    wr(3, 8'h02); tick(1);
    chk("R6 trigger flag software clear", pend_o, 0);
    wr(0, 8'h80);

    // set wins over software clear
    ev(2);
    tmr2_ovf = 1; wr_en = 1; wr_addr = 3; wr_data = 8'h01;
    tick(1);
    tmr2_ovf = 0; wr_en = 0;
    tick(1);
    chk("R12 set beats same-cycle clear", pend_o, 10'h020);
    wr(3, 8'h01); tick(1);
    chk("R12 later clear works", pend_o, 0);

    // ADC takeover
    wr(0, 8'h84);
    ext1_n = 0; tick(6);
    chk("R8 ext1 pin ignored under takeover", pend_o, 0);
    ev(8); tick(1);
    chk("R8 adc done sets ext1", pend_o, 10'h004);
    ack(2); tick(1);
    chk("R8 ack clears ext1", pend_o, 0);
    ext1_n = 1; tick(4);
    wr(0, 8'h80); tick(2);
    chk("R8 back to pin mode idle", pend_o, 0);

    // DDC
    ev(6); tick(1);
    chk("R9 ddc serial set", pend_o, 10'h100);
    ack(8); tick(1);
    chk("R9 ddc serial cleared by ack", pend_o, 0);
    ev(7); tick(1);
    ack(8); tick(1);
    chk("R9 ddc mode-1 flag survives ack", pend_o, 10'h100);
    wr(3, 8'h04); tick(1);
    chk("R9 ddc mode-1 software clear", pend_o, 0);
    ddc_mode = 1; tick(2);
    chk("R9 switch to mode 2 sets flag", pend_o, 10'h100);
    wr(3, 8'h08); tick(1);
    chk("R9 switch flag software clear", pend_o, 0);
    ddc_mode = 0; tick(3);
    chk("R9 switch to mode 1 no set", pend_o, 0);

    // USB per-bit clear sweep
    ev(10); ack(9); tick(1);
    chk("R10 ack does not clear usb", pend_o, 10'h200);
    wr(4, 8'h7F); tick(1);
    for (int b = 0; b < 7; b++) begin
      for (int m = 0; m < 128; m++) begin
        ev(10 + b); tick(1);
        wr(4, m); tick(1);
        chk($sformatf("R10 usb bit %0d mask %0h", b, m), pend_o, ((m >> b) & 1) ? 0 : 10'h200);
        wr(4, 8'h7F); tick(1);
      end
    end

    // enable sweep with all sources pending
    ext0_n = 0; ext1_n = 0; tick(5);
    ev(0); ev(1); ev(2); ev(3); ev(4); ev(5); ev(7); ev(10); tick(1);
    chk("R2 all sources pending", pend_o, 10'h3FF);
    for (int e = 0; e < 1024; e++) begin
      wr(1, e & 8'hFF); wr(2, e >> 8); tick(1);
      chk($sformatf("R2 enable pattern %0h", e), req_o, e);
    end
    wr(0, 8'h00); tick(1);
    chk("R2 global enable off gates req", req_o, 0);
    chk("R2 pend kept with global off", pend_o, 10'h3FF);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule